// File: doc/BRIEF.md
# Packed Byte Shuffle and Lane ALU

This block is a single-stage media arithmetic unit for a word made of two lanes, each lane holding two bytes. It accepts two operands and an opcode together with a valid strobe. One clock edge later it presents one result word. The result is either a rearrangement of bytes or halfwords drawn from the operands, a count of how many leading bits the two operands share, or one of four independent per-lane operations: add, arithmetic right shift, signed minimum and signed maximum.

The rearrangement opcodes are meant to be chained. Two halfword packs followed by two byte merges and one more pack pull every other byte out of a pair of words. The lane minimum and maximum opcodes are meant to be chained too: four issues compute a per-lane median of three vectors. The leading-same count, taken against a zero operand, gives the bit length of a value. That makes it useful for variable-length code sizing.

The lane width is the parameter `LANE_W`. A byte is half a lane and the word is two lanes. At the default of 16 the unit works on 32-bit words made of 8-bit bytes.

Top module: `pkmix_alu`

## Requirements
In the requirements below, byte k of a word is bits [k*LANE_W/2 +: LANE_W/2], byte 3 is the most significant, and lane 1 is the upper half of the word.

- R1: Opcode 0x0 (pack high) returns the upper half of A followed by the upper half of B: {A[hi], B[hi]}.
- R2: Opcode 0x1 (pack low) returns the lower half of A followed by the lower half of B: {A[lo], B[lo]}.
- R3: Opcode 0x2 (merge high) returns the bytes {A3, B3, A2, B2}, listed from most significant down.
- R4: Opcode 0x3 (merge low) returns the bytes {A1, B1, A0, B0}, listed from most significant down.
- R5: Opcode 0x4 (byte swap) returns the four bytes of A in reverse order, {A0, A1, A2, A3}. B has no effect.
- R6: Opcode 0x5 (leading same) returns the number of bit positions, counted from the MSB downward, in which A and B agree before the first position where they differ. Equal operands give the full word width. When B is zero, the word width minus the result is the bit length of A.
- R7: Opcode 0x6 (lane add) adds each lane of A to the matching lane of B modulo 2^LANE_W. No carry crosses from lane 0 into lane 1.
- R8: Opcode 0x7 (lane shift) shifts each lane of A arithmetically right. The shift amount is the low log2(LANE_W) bits of the matching lane of B.
- R9: Opcode 0x8 returns the per-lane signed minimum of A and B. Opcode 0x9 returns the per-lane signed maximum.
- R10: The chain min(max(min(p1,p2),p3), max(p1,p2)), built from opcodes 0x8 and 0x9, yields the per-lane signed median of p1, p2 and p3.
- R11: The result and its valid flag appear one clock after a valid input. In a cycle with no valid input, out_valid is 0 and the result keeps its previous value. Reset clears both the result and out_valid to 0.
- R12: Opcodes 0xA to 0xF return a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Opcode |
| a | input | 2*LANE_W | First operand |
| b | input | 2*LANE_W | Second operand |
| out_valid | output | 1 | Result holds a new value |
| result | output | 2*LANE_W | Registered result |

## Verification
The bench builds two copies of the block. The first uses `LANE_W = 4`, which gives an 8-bit word of four 2-bit bytes. At that size the bench applies every value of A against a spread of B values under every opcode. This reaches every shift amount, every pair of lane signs, both lane wrap-arounds and every possible leading-same count. It also runs random triples through the four-step median chain. The second copy uses the default `LANE_W = 16`. It replays the pack-and-merge walk that picks alternate bytes from 32-bit words, the byte swap, and the bit-length use of the leading-same count.

// File: rtl/pkmix_pkg.sv
// Package: opcode encoding shared by the lane ALU, its sub-blocks and its checker.
// Assumes a 4-bit opcode field; codes above OP_LMAX are reserved.
package pkmix_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PACKHI = 4'h0,
        OP_PACKLO = 4'h1,
        OP_MRGHI  = 4'h2,
        OP_MRGLO  = 4'h3,
        OP_BSWAP  = 4'h4,
        OP_LDSAME = 4'h5,
        OP_LADD   = 4'h6,
        OP_LASR   = 4'h7,
        OP_LMIN   = 4'h8,
        OP_LMAX   = 4'h9
    } pk_op_e;

    // Opcode class used by the top-level result select.
    typedef enum logic [1:0] {
        CLS_SHUF = 2'd0,
        CLS_LDS  = 2'd1,
        CLS_LANE = 2'd2,
        CLS_NONE = 2'd3
    } pk_cls_e;

    // Map an opcode to the sub-block that produces its result.
    function automatic pk_cls_e op_class(logic [OP_W-1:0] code);
        pk_cls_e cls;
        if (code <= OP_BSWAP)       cls = CLS_SHUF;
        else if (code == OP_LDSAME) cls = CLS_LDS;
        else if (code <= OP_LMAX)   cls = CLS_LANE;
        else                        cls = CLS_NONE;
        return cls;
    endfunction

endpackage

// File: rtl/pkmix_shuffle.sv
// Module: pkmix_shuffle
// Purely combinational byte and halfword rearrangement of two words.
// Assumes a word of four bytes, each BYTE_W bits, byte 3 most significant.
// Produces zero for opcodes outside the shuffle class.
module pkmix_shuffle
    import pkmix_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [OP_W-1:0]     op,
    input  logic [4*BYTE_W-1:0] a,
    input  logic [4*BYTE_W-1:0] b,
    output logic [4*BYTE_W-1:0] res
);
    localparam int NBYTES = 4;
    localparam int HALF_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] ab [NBYTES];
    logic [BYTE_W-1:0] bb [NBYTES];
    logic [BYTE_W-1:0] swapped [NBYTES];

    // Split both operands into byte arrays and form the reversed order of A.
    for (genvar k = 0; k < NBYTES; k++) begin : g_split
        assign ab[k]      = a[k*BYTE_W +: BYTE_W];
        assign bb[k]      = b[k*BYTE_W +: BYTE_W];
        assign swapped[k] = a[(NBYTES-1-k)*BYTE_W +: BYTE_W];
    end

    logic [4*BYTE_W-1:0] swap_word;

    // Reassemble the reversed bytes into one word.
    always_comb begin
        swap_word = '0;
        for (int k = 0; k < NBYTES; k++) begin
            swap_word[k*BYTE_W +: BYTE_W] = swapped[k];
        end
    end

    // Select the permutation the opcode asks for.
    always_comb begin
        unique case (op)
            OP_PACKHI: res = {a[2*HALF_W-1:HALF_W], b[2*HALF_W-1:HALF_W]};
            OP_PACKLO: res = {a[HALF_W-1:0], b[HALF_W-1:0]};
            OP_MRGHI:  res = {ab[3], bb[3], ab[2], bb[2]};
            OP_MRGLO:  res = {ab[1], bb[1], ab[0], bb[0]};
            OP_BSWAP:  res = swap_word;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/pkmix_ldsame.sv
// Module: pkmix_ldsame
// Counts the leading bit positions, from the MSB down, in which two words agree.
// Assumes WORD_W >= 2; equal words give WORD_W. The count is zero-extended to WORD_W.
module pkmix_ldsame #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] count
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] diff;
    logic [CNT_W-1:0]  run_len;

    assign diff = a ^ b;

    // Scan upward so the highest differing bit sets the final run length.
    always_comb begin
        run_len = CNT_W'(WORD_W);
        for (int i = 0; i < WORD_W; i++) begin
            if (diff[i]) begin
                run_len = CNT_W'(WORD_W - 1 - i);
            end
        end
    end

    // Widen the count to a full result word.
    always_comb begin
        count = '0;
        count[CNT_W-1:0] = run_len;
    end

endmodule

// File: rtl/pkmix_lane.sv
// Module: pkmix_lane
// One independent signed lane: wrapping add, arithmetic right shift,
// signed minimum and signed maximum. The shift amount is the low
// log2(LANE_W) bits of b. Produces zero for non-lane opcodes.
module pkmix_lane
    import pkmix_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res
);
    localparam int SH_W = $clog2(LANE_W);

    logic [SH_W-1:0]   shamt;
    logic              a_lt_b;
    logic [LANE_W-1:0] sum;
    logic [LANE_W-1:0] shifted;

    assign shamt = b[SH_W-1:0];

    // Lane-local arithmetic; the sum is truncated so no carry leaves the lane.
    always_comb begin
        sum     = a + b;
        shifted = LANE_W'($signed(a) >>> shamt);
        a_lt_b  = $signed(a) < $signed(b);
    end

    // Choose the lane result for the current opcode.
    always_comb begin
        unique case (op)
            OP_LADD: res = sum;
            OP_LASR: res = shifted;
            OP_LMIN: res = a_lt_b ? a : b;
            OP_LMAX: res = a_lt_b ? b : a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/pkmix_alu.sv
// Module: pkmix_alu (top)
// Single-stage packed media ALU. Operands and opcode are decoded
// combinationally and the selected result is captured in one output
// register, together with a valid flag. Assumes synchronous active-low
// reset and a word of two lanes, each lane two bytes.
module pkmix_alu
    import pkmix_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [3:0]            op,
    input  logic [2*LANE_W-1:0]   a,
    input  logic [2*LANE_W-1:0]   b,
    output logic                  out_valid,
    output logic [2*LANE_W-1:0]   result
);
    localparam int NLANES = 2;
    localparam int DATA_W = NLANES * LANE_W;
    localparam int BYTE_W = LANE_W / 2;

    logic [DATA_W-1:0] shuf_res;
    logic [DATA_W-1:0] lds_res;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] next_res;
    pk_cls_e           cls;

    pkmix_shuffle #(.BYTE_W(BYTE_W)) u_shuf (
        .op  (op),
        .a   (a),
        .b   (b),
        .res (shuf_res)
    );

    pkmix_ldsame #(.WORD_W(DATA_W)) u_lds (
        .a     (a),
        .b     (b),
        .count (lds_res)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        pkmix_lane #(.LANE_W(LANE_W)) u_lane (
            .op  (op),
            .a   (a[g*LANE_W +: LANE_W]),
            .b   (b[g*LANE_W +: LANE_W]),
            .res (lane_res[g*LANE_W +: LANE_W])
        );
    end

    assign cls = op_class(op);

    // Pick the sub-block result for the opcode class.
    always_comb begin
        unique case (cls)
            CLS_SHUF: next_res = shuf_res;
            CLS_LDS:  next_res = lds_res;
            CLS_LANE: next_res = lane_res;
            default:  next_res = '0;
        endcase
    end

    // Output register: load on valid input, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

endmodule

// File: rtl/pkmix_alu_chk.sv
// Module: pkmix_alu_chk
// Property checker for pkmix_alu. It watches the top-level ports only and
// is bound into every instance of the ALU.
module pkmix_alu_chk
    import pkmix_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [3:0]          op,
    input logic [2*LANE_W-1:0] a,
    input logic [2*LANE_W-1:0] b,
    input logic                out_valid,
    input logic [2*LANE_W-1:0] result
);
    localparam int DW = 2 * LANE_W;
    localparam int LW = LANE_W;

    // R11: the valid flag follows an accepted input by one cycle.
    a_r11_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(rst_n && in_valid));

    // R11: without a valid input the result register holds its value.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(result));

    // R1: pack high places the upper halves of A and B side by side.
    a_r1_pack_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && op == OP_PACKHI)
        |-> result == {$past(a[DW-1:LW]), $past(b[DW-1:LW])});

    // R6: identical operands agree in every position.
    a_r6_same_full: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && op == OP_LDSAME && a == b)
        |-> result == DW'(DW));

    // R7: the low lane of a lane add depends only on the low lanes.
    a_r7_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && op == OP_LADD)
        |-> result[LW-1:0] == $past(LW'(a[LW-1:0] + b[LW-1:0])));

    // R12: reserved opcodes clear the result.
    a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && op >= 4'hA) |-> result == '0);

endmodule

bind pkmix_alu pkmix_alu_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_pkmix_alu.sv
// Bench for pkmix_alu. u0 runs a small LANE_W=4 copy swept against an
// arithmetic model. u1 runs the default-width copy with directed words.
module sim_pkmix_alu;

    localparam int LW0 = 4;
    localparam int DW0 = 2 * LW0;
    localparam int BW0 = LW0 / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           v0 = 1'b0, v1 = 1'b0;
    logic [3:0]     op0 = '0, op1 = '0;
    logic [DW0-1:0] a0 = '0, b0 = '0;
    logic [31:0]    a1 = '0, b1 = '0;
    logic           ov0, ov1;
    logic [DW0-1:0] r0;
    logic [31:0]    r1;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    pkmix_alu #(.LANE_W(LW0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v0), .op(op0),
        .a(a0), .b(b0), .out_valid(ov0), .result(r0)
    );

    pkmix_alu u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .op(op1),
        .a(a1), .b(b1), .out_valid(ov1), .result(r1)
    );

    task automatic check(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(int op);
        case (op)
            0: return "R1 pack high";
            1: return "R2 pack low";
            2: return "R3 merge high";
            3: return "R4 merge low";
            4: return "R5 byte swap";
            5: return "R6 leading same";
            6: return "R7 lane add";
            7: return "R8 lane shift";
            8, 9: return "R9 lane min/max";
            default: return "R12 reserved";
        endcase
    endfunction

    function automatic int sgn(int v);
        return (v >= (1 << (LW0 - 1))) ? v - (1 << LW0) : v;
    endfunction

    function automatic int byt(int x, int k);
        return (x >> (k * BW0)) % (1 << BW0);
    endfunction

    function automatic int join4(int p3, int p2, int p1, int p0);
        return ((p3 * (1 << BW0) + p2) * (1 << BW0) + p1) * (1 << BW0) + p0;
    endfunction

    // Lane result of the small configuration, from signed integer arithmetic.
    function automatic int lane_ref(int op, int x, int y);
        int sx = sgn(x), sy = sgn(y), m = (1 << LW0) - 1, r;
        case (op)
            6: r = (x + y) & m;
            7: r = (sx >>> (y % LW0)) & m;
            8: r = ((sx < sy) ? sx : sy) & m;
            default: r = ((sx > sy) ? sx : sy) & m;
        endcase
        return r;
    endfunction

    function automatic int ref_fn(int op, int x, int y);
        int hl = 1 << LW0, cnt;
        case (op)
            0: return (x / hl) * hl + (y / hl);
            1: return (x % hl) * hl + (y % hl);
            2: return join4(byt(x, 3), byt(y, 3), byt(x, 2), byt(y, 2));
            3: return join4(byt(x, 1), byt(y, 1), byt(x, 0), byt(y, 0));
            4: return join4(byt(x, 0), byt(x, 1), byt(x, 2), byt(x, 3));
            5: begin
                cnt = 0;
                for (int i = DW0 - 1; i >= 0; i--) begin
                    if (((x >> i) & 1) != ((y >> i) & 1)) break;
                    cnt++;
                end
                return cnt;
            end
            6, 7, 8, 9:
                return lane_ref(op, x / hl, y / hl) * hl + lane_ref(op, x % hl, y % hl);
            default: return 0;
        endcase
    endfunction

    // Issue one operation on u0 at a falling edge; return the registered result.
    task automatic run0(int op, int x, int y, output int r);
        op0 = 4'(op); a0 = DW0'(x); b0 = DW0'(y); v0 = 1'b1;
        @(negedge clk);
        v0 = 1'b0;
        r = int'(r0);
    endtask

    task automatic run1(int op, logic [31:0] x, logic [31:0] y, output logic [31:0] r);
        op1 = 4'(op); a1 = x; b1 = y; v1 = 1'b1;
        @(negedge clk);
        v1 = 1'b0;
        r = r1;
    endtask

    function automatic int med3(int p, int q, int s);
        return p + q + s - ((p < q) ? ((p < s) ? p : s) : ((q < s) ? q : s))
                         - ((p > q) ? ((p > s) ? p : s) : ((q > s) ? q : s));
    endfunction

    initial begin
        int r, held;
        logic [31:0] w, pk_hi, pk_lo, m_hi, m_lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 reset out_valid", ov0, 0);
        check("R11 reset result", r0, 0);
        check("R11 reset result wide", r1, 0);

        // R1..R9: sweep every A against a spread of B for each opcode.
        for (int op = 0; op < 10; op++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y += 7) begin
                    run0(op, x, y, r);
                    check(tag_of(op), r, ref_fn(op, x, y));
                end
            end
        end
        // R12: reserved opcodes.
        for (int op = 10; op < 16; op++) begin
            for (int x = 0; x < 256; x += 3) begin
                run0(op, x, 255 - x, r);
                check(tag_of(op), r, 0);
            end
        end
        // R6: bit length from a zero second operand.
        for (int x = 0; x < 256; x++) begin
            run0(5, x, 0, r);
            check("R6 bit length", DW0 - r, (x == 0) ? 0 : $clog2(x + 1));
        end
        // R11: valid timing and hold.
        run0(6, 8'h12, 8'h34, r);
        held = r;
        check("R11 out_valid after issue", ov0, 1);
        op0 = 4'h4; a0 = 8'hA5; b0 = 8'h5A;
        @(negedge clk);
        check("R11 out_valid idle", ov0, 0);
        check("R11 result held", r0, held);

        // R10: median chain on random triples.
        for (int t = 0; t < 300; t++) begin
            int p1, p2, p3, t1, t2, t3, t4, e;
            p1 = int'($urandom % 256); p2 = int'($urandom % 256); p3 = int'($urandom % 256);
            run0(8, p1, p2, t1);
            run0(9, t1, p3, t2);
            run0(9, p1, p2, t3);
            run0(8, t2, t3, t4);
            e = (med3(sgn(p1 / 16), sgn(p2 / 16), sgn(p3 / 16)) & 15) * 16
              + (med3(sgn(p1 % 16), sgn(p2 % 16), sgn(p3 % 16)) & 15);
            check("R10 median", t4, e);
        end

        // Wide copy: alternate-byte extraction walk and directed cases.
        run1(0, 32'h11223344, 32'h55667788, pk_hi);
        check("R1 wide pack high", pk_hi, 32'h11225566);
        run1(1, 32'h11223344, 32'h55667788, pk_lo);
        check("R2 wide pack low", pk_lo, 32'h33447788);
        run1(2, pk_hi, pk_lo, m_hi);
        check("R3 wide merge high", m_hi, 32'h11332244);
        run1(3, pk_hi, pk_lo, m_lo);
        check("R4 wide merge low", m_lo, 32'h55776688);
        run1(0, m_hi, m_lo, w);
        check("R3 R4 alternate bytes", w, 32'h11335577);
        run1(4, 32'h11223344, 32'hFFFFFFFF, w);
        check("R5 wide byte swap", w, 32'h44332211);
        run1(5, 32'h0000001F, 32'h0, w);
        check("R6 wide bit length", 32 - w, 5);
        run1(5, 32'hCAFEF00D, 32'hCAFEF00D, w);
        check("R6 wide identical", w, 32);
        run1(6, 32'h0001FFFF, 32'h00010001, w);
        check("R7 wide no carry", w, 32'h00020000);
        run1(7, 32'h80004000, 32'h000F0002, w);
        check("R8 wide shift", w, 32'hFFFF1000);
        run1(8, 32'h7FFF8000, 32'h80007FFF, w);
        check("R9 wide min", w, 32'h80008000);
        run1(9, 32'h7FFF8000, 32'h80007FFF, w);
        check("R9 wide max", w, 32'h7FFF7FFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule